// File: doc/BRIEF.md
# Zero-Crossing Interval Measure-and-Replay Timer

This block measures how long a zero-crossing comparator stays low and then plays that length back. It counts system clocks while the comparator level is low. On the next low-to-high transition it loads the count into a second counter, which runs down to zero and then raises a single-clock output pulse. The result is an event that trails the crossing by the same number of clocks that the previous low half-cycle lasted.

The comparator level can change at any time relative to the clock, so it first passes through a synchronizer. After that, every action happens on one clock edge: counting, the carry between the two 4-bit stages of the up-counter, the capture and the clear. Because the two stages can never disagree, a capture cannot pick up a half-updated value. Both counters are visible on debug outputs.

Top module: `zc_replay_timer`

## Requirements
- R1: The up-counter advances by one on each clock for which the synchronized comparator level is low, and holds while it is high. A comparator held low for L clock periods yields a captured value of L.
- R2: The up-counter is built from 4-bit stages. The upper stage advances only when the lower stage rolls over from 0xF, and both stages update on the same edge, so 0x4F is followed by 0x50 (80). Every captured value from 1 to 254 equals the number of low clocks.
- R3: A low-to-high change of the comparator input loads the up-count into the down-counter on the third rising clock edge after the change (two synchronizer stages plus one edge-detect stage). The down-counter value is shown on `down_dbg_o`.
- R4: The up-counter returns to 0 on the same edge that captures it, so `up_dbg_o` reads 0 right after a capture.
- R5: The up-counter saturates at 255 and does not wrap. Any low period of 255 clocks or more captures 255.
- R6: For a captured value N, `pulse_o` goes high N+1 clocks after the capture edge, which is the (N+4)th rising edge after the comparator rises. A value of 0 therefore pulses on the clock right after the capture.
- R7: `pulse_o` is high for exactly one clock, once per capture that reaches timeout.
- R8: A capture that arrives before the down-counter has timed out reloads it with the new value and cancels the pending pulse. Only the new interval produces a pulse.
- R9: While `rst` is high, both counters read 0 and `pulse_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator level from the zero-crossing detector |
| pulse_o | output | 1 | One-clock replay pulse at down-counter timeout |
| up_dbg_o | output | 8 | Debug view of the interval up-counter |
| down_dbg_o | output | 8 | Debug view of the replay down-counter |

## Verification
Low periods are swept over every length from 1 to 260 clocks. This exercises every lower-stage rollover, the 0x4F to 0x50 carry that exposes a torn stage update, and the region from 255 upward where saturation and wrapping give different captured values and pulse delays. Each sweep step checks the captured value, the cleared up-counter, the exact cycle of the pulse and its single-clock width. A separate pattern shortens the high period so that a second rising edge arrives while a long replay is still pending. That pattern separates a design that reloads and cancels from one that lets the stale pulse through.

// File: rtl/zcr_pkg.sv
package zcr_pkg;
  typedef enum logic {
    REPLAY_IDLE = 1'b0,
    REPLAY_RUN  = 1'b1
  } replay_state_t;
endpackage

// File: rtl/zcr_sync.sv
module zcr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

  // R3: an edge event lasts a single clock
  p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/zcr_nibble_cnt.sv
module zcr_nibble_cnt #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inc,
  input  logic                     clr,
  output logic [NIB_W*NUM_NIB-1:0] count_o
);
  localparam int W = NIB_W * NUM_NIB;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [NUM_NIB-1:0] carry;
  logic               at_max;

  assign at_max   = (count_o == MAXV);
  assign carry[0] = inc & ~at_max;

  generate
    for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
      logic [NIB_W-1:0] nib_q;
      assign count_o[i*NIB_W +: NIB_W] = nib_q;
      if (i < NUM_NIB - 1) begin : g_carry
        assign carry[i+1] = carry[i] & (&nib_q);
      end
      always_ff @(posedge clk) begin
        if (rst || clr)    nib_q <= '0;
        else if (carry[i]) nib_q <= nib_q + 1'b1;
      end
    end
  endgenerate

  // R2: whole-word increment, stages never torn
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && count_o != MAXV) |=> count_o == $past(count_o) + 1'b1);
  // R5: saturate instead of wrapping
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && count_o == MAXV) |=> count_o == MAXV);
  // R1: no counting while disabled
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(count_o));
  // R4: cleared after capture
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> count_o == '0);
endmodule

// File: rtl/zcr_replay.sv
module zcr_replay
  import zcr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] down_o,
  output logic         pulse_o
);
  replay_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      down_o  <= '0;
      state_q <= REPLAY_IDLE;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (load) begin
        down_o  <= load_val;
        state_q <= REPLAY_RUN;
      end else if (state_q == REPLAY_RUN) begin
        if (down_o == '0) begin
          pulse_o <= 1'b1;
          state_q <= REPLAY_IDLE;
        end else begin
          down_o <= down_o - 1'b1;
        end
      end
    end
  end

  // R3: load takes the presented value
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> down_o == $past(load_val));
  // R8: a reload suppresses any pulse on the following cycle
  p_cancel_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> !pulse_o);
  // R7: pulse width is one clock
  p_one_wide_r7: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R6: pulse only from a zero count
  p_pulse_zero_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> down_o == '0);
endmodule

// File: rtl/zc_replay_timer.sv
module zc_replay_timer #(
  parameter int NIB_W       = 4,
  parameter int NUM_NIB     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmp_in,
  output logic                     pulse_o,
  output logic [NIB_W*NUM_NIB-1:0] up_dbg_o,
  output logic [NIB_W*NUM_NIB-1:0] down_dbg_o
);
  localparam int W = NIB_W * NUM_NIB;

  logic cmp_level;
  logic cmp_rise;

  zcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (cmp_in),
    .level_o  (cmp_level),
    .rise_o   (cmp_rise)
  );

  zcr_nibble_cnt #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_up (
    .clk     (clk),
    .rst     (rst),
    .inc     (~cmp_level),
    .clr     (cmp_rise),
    .count_o (up_dbg_o)
  );

  zcr_replay #(.W(W)) u_down (
    .clk      (clk),
    .rst      (rst),
    .load     (cmp_rise),
    .load_val (up_dbg_o),
    .down_o   (down_dbg_o),
    .pulse_o  (pulse_o)
  );

  // R3: capture moves the up-count into the down-counter on one edge
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    cmp_rise |=> down_dbg_o == $past(up_dbg_o));
endmodule

// File: tb/sim_zc_replay_timer.sv
module sim_zc_replay_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_in = 1'b0;
  logic       pulse_o;
  logic [7:0] up_dbg_o;
  logic [7:0] down_dbg_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  zc_replay_timer u0 (
    .clk(clk), .rst(rst), .cmp_in(cmp_in),
    .pulse_o(pulse_o), .up_dbg_o(up_dbg_o), .down_dbg_o(down_dbg_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Low for len clocks, then high; check capture, clear, pulse cycle and width.
  task automatic interval(input int len);
    int exp_val;
    int first_k;
    int n_pulse;
    exp_val = (len > 255) ? 255 : len;
    cmp_in = 1'b0;
    repeat (len) @(negedge clk);
    cmp_in = 1'b1;
    first_k = -1;
    n_pulse = 0;
    for (int k = 1; k <= exp_val + 6; k++) begin
      @(negedge clk);
      if (k == 3) begin
        check(down_dbg_o == exp_val[7:0], (len > 254) ? "R5" : "R2", down_dbg_o, exp_val);
        check(up_dbg_o == 8'd0, "R4", up_dbg_o, 0);
      end
      if (pulse_o) begin
        n_pulse++;
        if (first_k < 0) first_k = k;
      end
    end
    check(first_k == exp_val + 4, "R6", first_k, exp_val + 4);
    check(n_pulse == 1, "R7", n_pulse, 1);
    check(up_dbg_o == 8'd0, "R1", up_dbg_o, 0);
  endtask

  initial begin
    int n_pulse;
    int first_k;
    repeat (5) @(negedge clk);
    check(pulse_o == 1'b0, "R9", pulse_o, 0);
    check(up_dbg_o == 8'd0, "R9", up_dbg_o, 0);
    check(down_dbg_o == 8'd0, "R9", down_dbg_o, 0);
    rst = 1'b0;
    cmp_in = 1'b1;
    repeat (30) @(negedge clk);

    // R1 R2 R5 R6 R7 sweep of every low length 1..260
    for (int len = 1; len <= 260; len++) interval(len);

    // R8: second rise during a pending replay
    cmp_in = 1'b0;
    repeat (100) @(negedge clk);
    cmp_in = 1'b1;
    n_pulse = 0;
    repeat (20) begin
      @(negedge clk);
      if (pulse_o) n_pulse++;
    end
    cmp_in = 1'b0;
    repeat (7) begin
      @(negedge clk);
      if (pulse_o) n_pulse++;
    end
    cmp_in = 1'b1;
    first_k = -1;
    for (int k = 1; k <= 120; k++) begin
      @(negedge clk);
      if (k == 3) check(down_dbg_o == 8'd7, "R8", down_dbg_o, 7);
      if (pulse_o) begin
        n_pulse++;
        if (first_k < 0) first_k = k;
      end
    end
    check(first_k == 11, "R8", first_k, 11);
    check(n_pulse == 1, "R8", n_pulse, 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule